// File: doc/BRIEF.md
# Nibble Data Memory and Pointer Unit

This block holds the working data of a small 4-bit controller core. It has 64 four-bit cells, seen as 4 columns of 16 rows. A column register and a row register together point at one cell. Each cycle the core issues one operation on the pointed cell. It can swap the cell with the accumulator, set or clear one bit of the cell, or move the row pointer while it swaps. The core's accumulator register sits outside this block: it drives `acc_i`, and on a swap it loads `acc_o`.

A single 16-entry table, indexed by the row register, supplies four things: the next and previous row, the one-hot line mask and the row condition flags. The row pointer also addresses a 16-bit staging pattern for the line outputs. A move operation copies that pattern into an output latch, and the low 13 bits of the output latch drive the line pins. A second read port lets a debug client read any cell without disturbing the core's operations.

Top module: `nmem_ptr_unit`

## Requirements
- R1: `acc_o` always shows the cell at address {column, row}. `dbg_data_o` always shows the cell at `dbg_addr_i`, with the column in the top 2 bits and the row in the low 4 bits.
- R2: Bit set (op 1) ORs the pointed cell with 1<<opnd[1:0]. Bit clear (op 2) ANDs the pointed cell with the complement of that mask. Neither operation changes any other cell.
- R3: Exchange (op 3) writes `acc_i` into the pointed cell and replaces the column with column XOR opnd. `acc_o` shows the old cell value in the cycle of the operation. The write and the column update take effect at the same clock edge.
- R4: Exchange-up (op 4) and exchange-down (op 5) perform R3 and also add or subtract one on the row, wrapping modulo 16.
- R5: `skip_o` is high only during exchange-up with row 15 and during exchange-down with row 0. Exchange-down at row 15 does not raise it.
- R6: `row_zero_o`, `row_thirteen_o` and `row_last_o` are high exactly when the row is 0, 13 and 15 respectively.
- R7: Line set (op 6) sets bit [row] of the staging pattern and line clear (op 7) clears it. At row 15 either operation acts on all 16 bits.
- R8: Line move (op 8) copies the staging pattern to the output latch. `lines_o` is the low 13 bits of the output latch and changes only after a move.
- R9: An asynchronous active-low reset clears the column, the row and both line latches. The memory cells are left undefined.
- R10: Op 0 and op codes 9 to 15 are idle. Operations other than exchanges leave the column and the row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| opnd_i | input | 2 | Operand: bit select or column XOR value |
| acc_i | input | 4 | Accumulator value to store on exchange |
| acc_o | output | 4 | Pointed cell, loaded into the accumulator on exchange |
| skip_o | output | 1 | Skip request from exchange-up or exchange-down |
| row_zero_o | output | 1 | Row equals 0 |
| row_thirteen_o | output | 1 | Row equals 13 |
| row_last_o | output | 1 | Row equals 15 |
| lines_o | output | 13 | Line outputs from the second latch |
| dbg_addr_i | input | 6 | Debug read address |
| dbg_data_o | output | 4 | Debug read data |

## Verification
The bench builds the block with its default parameters: 2 column bits, 4 row bits and 13 lines. These values leave row 13 as a valid row with no line pin behind it, so a set at that row must stay hidden from `lines_o`. Row 15 falls into the all-bits case for the line operations, and the wrap at both ends of the row range produces the skip requests. The column XOR can return to any column in one exchange. This lets the bench fill all 64 cells by exchange-up alone and then read every cell back through the debug port.

// File: rtl/nmem_pkg.sv
package nmem_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [3:0] {
    OP_IDLE = 4'd0,
    OP_BSET = 4'd1,
    OP_BCLR = 4'd2,
    OP_XCH  = 4'd3,
    OP_XCHU = 4'd4,
    OP_XCHD = 4'd5,
    OP_LSET = 4'd6,
    OP_LCLR = 4'd7,
    OP_LMOV = 4'd8
  } op_e;

  function automatic logic [NIB_W-1:0] bit_or_mask(input logic [1:0] sel);
    logic [NIB_W-1:0] m;
    m = '0;
    m[sel] = 1'b1;
    return m;
  endfunction

  function automatic logic [NIB_W-1:0] bit_and_mask(input logic [1:0] sel);
    return ~bit_or_mask(sel);
  endfunction

  function automatic logic is_exchange(input op_e op);
    return (op == OP_XCH) || (op == OP_XCHU) || (op == OP_XCHD);
  endfunction
endpackage

// File: rtl/nmem_row_table.sv
module nmem_row_table #(
  parameter int ROW_W  = 4,
  parameter int LINE_W = 13
) (
  input  logic [ROW_W-1:0]        row_i,
  output logic [ROW_W-1:0]        next_o,
  output logic [ROW_W-1:0]        prev_o,
  output logic [(1<<ROW_W)-1:0]   line_or_o,
  output logic [(1<<ROW_W)-1:0]   line_and_o,
  output logic                    is_first_o,
  output logic                    is_line_end_o,
  output logic                    is_last_o
);
  localparam int ROWS = 1 << ROW_W;

  logic [ROW_W-1:0] next_tbl [ROWS];
  logic [ROW_W-1:0] prev_tbl [ROWS];
  logic [ROWS-1:0]  or_tbl   [ROWS];
  logic [2:0]       flag_tbl [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_entry
    assign next_tbl[g] = ROW_W'((g + 1) % ROWS);
    assign prev_tbl[g] = ROW_W'((g + ROWS - 1) % ROWS);
    if (g == ROWS - 1) begin : g_all
      assign or_tbl[g] = '1;
    end else begin : g_one
      assign or_tbl[g] = ROWS'(1) << g;
    end
    assign flag_tbl[g] = {(g == ROWS - 1), (g == LINE_W), (g == 0)};
  end

  assign next_o        = next_tbl[row_i];
  assign prev_o        = prev_tbl[row_i];
  assign line_or_o     = or_tbl[row_i];
  assign line_and_o    = ~or_tbl[row_i];
  assign is_first_o    = flag_tbl[row_i][0];
  assign is_line_end_o = flag_tbl[row_i][1];
  assign is_last_o     = flag_tbl[row_i][2];
endmodule

// File: rtl/nmem_store.sv
module nmem_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] sys_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] sys_rdata_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[sys_addr_i] <= wdata_i;
  end

  assign sys_rdata_o = cells[sys_addr_i];
  assign dbg_rdata_o = cells[dbg_addr_i];
endmodule

// File: rtl/nmem_line_latch.sv
module nmem_line_latch #(
  parameter int PAT_W  = 16,
  parameter int LINE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              move_i,
  input  logic [PAT_W-1:0]  or_mask_i,
  input  logic [PAT_W-1:0]  and_mask_i,
  output logic [LINE_W-1:0] lines_o
);
  logic [PAT_W-1:0] stage_q;
  logic [PAT_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (set_i)      stage_q <= stage_q | or_mask_i;
      else if (clr_i) stage_q <= stage_q & and_mask_i;
      if (move_i)     out_q   <= stage_q;
    end
  end

  assign lines_o = out_q[LINE_W-1:0];

  a_r8_move_copies: assert property (@(posedge clk) disable iff (!rst_n)
    move_i |=> out_q == $past(stage_q));
  a_r7_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (stage_q & $past(or_mask_i)) == $past(or_mask_i));
endmodule

// File: rtl/nmem_ptr_unit.sv
module nmem_ptr_unit
  import nmem_pkg::*;
#(
  parameter int COL_W  = 2,
  parameter int ROW_W  = 4,
  parameter int LINE_W = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 op_i,
  input  logic [COL_W-1:0]           opnd_i,
  input  logic [NIB_W-1:0]           acc_i,
  output logic [NIB_W-1:0]           acc_o,
  output logic                       skip_o,
  output logic                       row_zero_o,
  output logic                       row_thirteen_o,
  output logic                       row_last_o,
  output logic [LINE_W-1:0]          lines_o,
  input  logic [COL_W+ROW_W-1:0]     dbg_addr_i,
  output logic [NIB_W-1:0]           dbg_data_o
);
  localparam int ADDR_W = COL_W + ROW_W;
  localparam int ROWS   = 1 << ROW_W;

  op_e              op;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_next, row_prev;
  logic [ROWS-1:0]  line_or, line_and;
  logic             at_first, at_line_end, at_last;
  logic [NIB_W-1:0] cell_rd, cell_wd;
  logic             cell_we;
  logic             exch_op;

  assign op      = op_e'(op_i);
  assign exch_op = is_exchange(op);

  nmem_row_table #(.ROW_W(ROW_W), .LINE_W(LINE_W)) u_table (
    .row_i        (row_q),
    .next_o       (row_next),
    .prev_o       (row_prev),
    .line_or_o    (line_or),
    .line_and_o   (line_and),
    .is_first_o   (at_first),
    .is_line_end_o(at_line_end),
    .is_last_o    (at_last)
  );

  always_comb begin
    cell_we = 1'b1;
    cell_wd = acc_i;
    case (op)
      OP_BSET: cell_wd = cell_rd | bit_or_mask(opnd_i[1:0]);
      OP_BCLR: cell_wd = cell_rd & bit_and_mask(opnd_i[1:0]);
      OP_XCH, OP_XCHU, OP_XCHD: cell_wd = acc_i;
      default: cell_we = 1'b0;
    endcase
  end

  nmem_store #(.ADDR_W(ADDR_W), .DATA_W(NIB_W)) u_store (
    .clk        (clk),
    .we_i       (cell_we),
    .sys_addr_i ({col_q, row_q}),
    .wdata_i    (cell_wd),
    .sys_rdata_o(cell_rd),
    .dbg_addr_i (dbg_addr_i),
    .dbg_rdata_o(dbg_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (exch_op) begin
      col_q <= col_q ^ opnd_i;
      if (op == OP_XCHU)      row_q <= row_next;
      else if (op == OP_XCHD) row_q <= row_prev;
    end
  end

  nmem_line_latch #(.PAT_W(ROWS), .LINE_W(LINE_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (op == OP_LSET),
    .clr_i     (op == OP_LCLR),
    .move_i    (op == OP_LMOV),
    .or_mask_i (line_or),
    .and_mask_i(line_and),
    .lines_o   (lines_o)
  );

  assign acc_o          = cell_rd;
  assign skip_o         = ((op == OP_XCHU) && at_last) || ((op == OP_XCHD) && at_first);
  assign row_zero_o     = at_first;
  assign row_thirteen_o = at_line_end;
  assign row_last_o     = at_last;

  // Assertions
  a_r1_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr_i == {col_q, row_q}) |-> (dbg_data_o == acc_o));
  a_r2_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BSET) |=> acc_o == ($past(acc_o) | (NIB_W'(1) << $past(opnd_i[1:0]))));
  a_r3_col_flip: assert property (@(posedge clk) disable iff (!rst_n)
    exch_op |=> col_q == ($past(col_q) ^ $past(opnd_i)));
  a_r4_row_up: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XCHU) |=> row_q == ROW_W'($past(row_q) + 1'b1));
  a_r4_row_down: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XCHD) |=> row_q == ROW_W'($past(row_q) - 1'b1));
  a_r5_skip_src: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> ((op == OP_XCHU) || (op == OP_XCHD)));
  a_r6_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_zero_o, row_thirteen_o, row_last_o}));
  a_r8_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_LMOV) |=> $stable(lines_o));
  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exch_op |=> ($stable(col_q) && $stable(row_q)));
endmodule

// File: tb/nmem_ptr_unit_tb.sv
module nmem_ptr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [1:0]  opnd_i = 2'd0;
  logic [3:0]  acc_i = 4'd0;
  logic [3:0]  acc_o;
  logic        skip_o, row_zero_o, row_thirteen_o, row_last_o;
  logic [12:0] lines_o;
  logic [5:0]  dbg_addr_i = 6'd0;
  logic [3:0]  dbg_data_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmem_ptr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_i(opnd_i), .acc_i(acc_i),
    .acc_o(acc_o), .skip_o(skip_o), .row_zero_o(row_zero_o),
    .row_thirteen_o(row_thirteen_o), .row_last_o(row_last_o),
    .lines_o(lines_o), .dbg_addr_i(dbg_addr_i), .dbg_data_o(dbg_data_o)
  );

  // {op, opnd, acc_in, expected acc_o, expected skip, expected {r15,r13,r0}}
  localparam logic [17:0] VEC [NVEC] = '{
    {4'd5, 2'd0, 4'd9, 4'd0,  1'b1, 3'b001},  // R5 down at row 0
    {4'd4, 2'd0, 4'd5, 4'd15, 1'b1, 3'b100},  // R4 wrap, R5 up at row 15
    {4'd1, 2'd2, 4'd0, 4'd9,  1'b0, 3'b001},  // R2 set bit 2
    {4'd2, 2'd0, 4'd0, 4'd13, 1'b0, 3'b001},  // R2 clear bit 0
    {4'd3, 2'd3, 4'd1, 4'd12, 1'b0, 3'b001},  // R3 exchange, col 0->3
    {4'd4, 2'd2, 4'd7, 4'd9,  1'b0, 3'b001},  // R4 up, col 3->1
    {4'd5, 2'd1, 4'd2, 4'd4,  1'b0, 3'b000},  // R4 down, col 1->0
    {4'd0, 2'd0, 4'd0, 4'd1,  1'b0, 3'b001},  // R10 idle
    {4'd5, 2'd1, 4'd3, 4'd1,  1'b1, 3'b001},  // R4 wrap down, col 0->1
    {4'd2, 2'd3, 4'd0, 4'd2,  1'b0, 3'b100},  // R2 clear bit 3
    {4'd1, 2'd3, 4'd0, 4'd2,  1'b0, 3'b100},  // R2 set bit 3
    {4'd9, 2'd3, 4'd5, 4'd10, 1'b0, 3'b100}   // R10 unused code idle
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [1:0] opnd, input logic [3:0] acc);
    @(negedge clk);
    op_i = op; opnd_i = opnd; acc_i = acc;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R9 lines", int'(lines_o), 0);
    check("R9 row flags", int'({row_last_o, row_thirteen_o, row_zero_o}), 1);
    check("R9 skip", int'(skip_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // fill cell {c,r} with (r + 3c) mod 16 using exchange-up only
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 16; r++) begin
        logic [1:0] flip;
        flip = (r == 15) ? 2'(c ^ ((c + 1) % 4)) : 2'd0;
        drive(4'd4, flip, 4'((r + 3 * c) % 16));
      end
    end
    drive(4'd0, 2'd0, 4'd0);
    check("R3 col wrap back to 0 acc", int'(acc_o), 0);

    // R1 debug port readback
    for (int a = 0; a < 64; a++) begin
      dbg_addr_i = 6'(a);
      #1;
      check("R1 debug read", int'(dbg_data_o), ((a % 16) + 3 * (a / 16)) % 16);
    end

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][17:14], VEC[i][13:12], VEC[i][11:8]);
      check("R1/R3 acc_o", int'(acc_o), int'(VEC[i][7:4]));
      check("R5 skip", int'(skip_o), int'(VEC[i][3]));
      check("R6 flags", int'({row_last_o, row_thirteen_o, row_zero_o}), int'(VEC[i][2:0]));
    end

    // R7/R8 line latch, pointer at col 1 row 15
    drive(4'd6, 2'd0, 4'd0);
    drive(4'd0, 2'd0, 4'd0);
    check("R8 staging hidden", int'(lines_o), 0);
    drive(4'd8, 2'd0, 4'd0);
    drive(4'd0, 2'd0, 4'd0);
    check("R7 row15 sets all", int'(lines_o), 13'h1FFF);
    drive(4'd7, 2'd0, 4'd0);
    drive(4'd0, 2'd0, 4'd0);
    check("R8 hold until move", int'(lines_o), 13'h1FFF);
    drive(4'd8, 2'd0, 4'd0);
    drive(4'd0, 2'd0, 4'd0);
    check("R7 row15 clears all", int'(lines_o), 0);

    drive(4'd5, 2'd0, 4'd0);
    check("R5 no skip down at 15", int'(skip_o), 0);
    drive(4'd5, 2'd0, 4'd0);
    drive(4'd0, 2'd0, 4'd0);
    check("R6 row13 flag", int'({row_last_o, row_thirteen_o, row_zero_o}), 3'b010);
    drive(4'd6, 2'd0, 4'd0);
    drive(4'd8, 2'd0, 4'd0);
    drive(4'd0, 2'd0, 4'd0);
    check("R8 bit13 not on pins", int'(lines_o), 0);
    drive(4'd5, 2'd0, 4'd0);
    drive(4'd6, 2'd0, 4'd0);
    drive(4'd8, 2'd0, 4'd0);
    drive(4'd0, 2'd0, 4'd0);
    check("R7 row12 one-hot", int'(lines_o), 13'h1000);
    check("R10 col kept by line ops", int'(acc_o), 15);
    drive(4'd7, 2'd0, 4'd0);
    drive(4'd8, 2'd0, 4'd0);
    drive(4'd0, 2'd0, 4'd0);
    check("R7 row12 clear", int'(lines_o), 0);
    dbg_addr_i = 6'd31;
    #1;
    check("R4 writes by down-steps", int'(dbg_data_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule